// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the central sequencer for a 32-bit load/store datapath that takes several clock cycles for each instruction. It steps through a small set of states and, in each state, drives a fixed vector of datapath controls: memory read and write strobes, the memory address source, the instruction register load, the two ALU operand selects, the ALU operation class, the program counter load strobes and source, and the register-file write enable, destination select and write-data select.

The only data input is the 6-bit instruction opcode. The datapath holds this opcode steady in its instruction register from the decode cycle until the next fetch. Every output is a function of the current state alone, so each output is steady for the whole cycle. Five instruction classes are handled: load word, store word, register-type ALU operation, branch-if-equal and jump. An opcode that matches none of these sends the sequencer straight back to fetch.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the sequencer enters the fetch state. The fetch state is seen at the ports as `mem_rd`=1, `ir_load`=1, `pc_load`=1, `alu_b_sel`=01 and every other output 0.
- R2: The fetch state always moves to the decode state on the next cycle, whatever the value of `opcode`.
- R3: The decode state drives `alu_b_sel`=11 with all other outputs 0. It then moves to address calculation for opcode 100011 (load) or 101011 (store), to execute for 000000 (register-type), to branch for 000100 (branch-equal) and to jump for 000010 (jump).
- R4: The address calculation state drives `alu_a_sel`=1 and `alu_b_sel`=10. It moves to memory-read if the opcode is 100011 and to memory-write otherwise.
- R5: The memory-read state drives `mem_rd`=1 and `addr_sel_data`=1, then moves to load writeback.
- R6: The load writeback state drives `rf_we`=1 and `rf_wdata_sel`=1 with `rf_dst_sel`=0, then moves to fetch.
- R7: The memory-write state drives `mem_wr`=1 and `addr_sel_data`=1, then moves to fetch.
- R8: The execute state drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. It is followed by a writeback state with `rf_we`=1, `rf_dst_sel`=1 and `rf_wdata_sel`=0, which moves to fetch.
- R9: The branch state drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_load_if_zero`=1 and `pc_src`=01, then moves to fetch.
- R10: The jump state drives `pc_load`=1 and `pc_src`=10, then moves to fetch.
- R11: In the decode state, any opcode outside the five listed values returns the sequencer to fetch on the next cycle.
- R12: In every state, any output not named for that state is 0. In particular, `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel_data | output | 1 | Memory address source: 0 = program counter, 1 = ALU result register |
| ir_load | output | 1 | Instruction register load |
| alu_a_sel | output | 1 | ALU operand A: 0 = program counter, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 = register B, 01 = constant 4, 10 = extended immediate, 11 = shifted immediate |
| alu_op | output | 2 | ALU class: 00 = add, 01 = subtract, 10 = use function field |
| pc_load | output | 1 | Unconditional program counter load |
| pc_load_if_zero | output | 1 | Program counter load when the ALU result is zero |
| pc_src | output | 2 | Program counter source: 00 = ALU, 01 = ALU result register, 10 = jump target |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| rf_wdata_sel | output | 1 | Write data: 0 = ALU result register, 1 = memory data register |

## Verification
Every state has its own output vector, so a wrong state register shows at the ports in the same cycle: the output vector belongs to a different state or to no state. A wrong transition shows one clock edge after it happens. The bench runs all 64 opcode values through a full instruction each, and changes the opcode during fetch to show it has no effect there. It compares the whole output vector in every cycle against a path it works out from the opcode. A misrouted branch, a missing writeback, or a stray strobe is therefore caught within the instruction where it occurs.

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel_data,
  output logic       ir_load,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic       pc_load,
  output logic       pc_load_if_zero,
  output logic [1:0] pc_src,
  output logic       rf_we,
  output logic       rf_dst_sel,
  output logic       rf_wdata_sel
);

  localparam logic [5:0] OP_LD  = 6'b100011;
  localparam logic [5:0] OP_ST  = 6'b101011;
  localparam logic [5:0] OP_RR  = 6'b000000;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_JMP = 6'b000010;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB,
    ST_STMEM, ST_REXEC, ST_RWB, ST_BR, ST_JMP
  } st_t;

  st_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_FETCH;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx = ST_FETCH;
    case (st)
      ST_FETCH:  st_nx = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LD, OP_ST: st_nx = ST_ADDR;
          OP_RR:        st_nx = ST_REXEC;
          OP_BEQ:       st_nx = ST_BR;
          OP_JMP:       st_nx = ST_JMP;
          default:      st_nx = ST_FETCH;
        endcase
      end
      ST_ADDR:   st_nx = (opcode == OP_LD) ? ST_LDMEM : ST_STMEM;
      ST_LDMEM:  st_nx = ST_LDWB;
      ST_REXEC:  st_nx = ST_RWB;
      default:   st_nx = ST_FETCH;
    endcase
  end

  assign mem_rd          = (st == ST_FETCH) || (st == ST_LDMEM);
  assign mem_wr          = (st == ST_STMEM);
  assign addr_sel_data   = (st == ST_LDMEM) || (st == ST_STMEM);
  assign ir_load         = (st == ST_FETCH);
  assign alu_a_sel       = (st == ST_ADDR) || (st == ST_REXEC) || (st == ST_BR);
  assign alu_b_sel       = (st == ST_FETCH)  ? 2'b01 :
                           (st == ST_DECODE) ? 2'b11 :
                           (st == ST_ADDR)   ? 2'b10 : 2'b00;
  assign alu_op          = (st == ST_REXEC) ? 2'b10 :
                           (st == ST_BR)    ? 2'b01 : 2'b00;
  assign pc_load         = (st == ST_FETCH) || (st == ST_JMP);
  assign pc_load_if_zero = (st == ST_BR);
  assign pc_src          = (st == ST_BR)  ? 2'b01 :
                           (st == ST_JMP) ? 2'b10 : 2'b00;
  assign rf_we           = (st == ST_LDWB) || (st == ST_RWB);
  assign rf_dst_sel      = (st == ST_RWB);
  assign rf_wdata_sel    = (st == ST_LDWB);

  a_r1_reset_fetch: assert property (@(posedge clk)
    rst |=> (ir_load && mem_rd && pc_load && !rf_we && !mem_wr));

  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (alu_b_sel == 2'b11 && !ir_load && !mem_rd));

  a_r3_decode_mem: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && (opcode == OP_LD || opcode == OP_ST)) |=> (alu_b_sel == 2'b10 && alu_a_sel));

  a_r11_decode_unknown: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && opcode != OP_LD && opcode != OP_ST && opcode != OP_RR &&
     opcode != OP_BEQ && opcode != OP_JMP) |=> ir_load);

  a_r5_ldmem_to_wb: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel_data) |=> (rf_we && rf_wdata_sel));

  a_r6_writeback_to_fetch: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> ir_load);

  a_r7_store_to_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_load);

  a_r8_exec_to_wb: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b10) |=> (rf_we && rf_dst_sel));

  a_r9_branch_to_fetch: assert property (@(posedge clk) disable iff (rst)
    pc_load_if_zero |=> ir_load);

  a_r10_jump_to_fetch: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b10) |=> ir_load);

  a_r12_no_rd_wr: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sim_mcyc_ctrl.sv
module sim_mcyc_ctrl;
  localparam int PERIOD = 10;

  logic clk = 0;
  logic rst = 1;
  logic [5:0] opcode = '0;
  logic mem_rd, mem_wr, addr_sel_data, ir_load, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic pc_load, pc_load_if_zero, rf_we, rf_dst_sel, rf_wdata_sel;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mcyc_ctrl u0 (.clk(clk), .rst(rst), .opcode(opcode), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr_sel_data(addr_sel_data), .ir_load(ir_load), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_load(pc_load),
    .pc_load_if_zero(pc_load_if_zero), .pc_src(pc_src), .rf_we(rf_we),
    .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel));

  // vector order: rd wr adsel irld asel bsel[2] op[2] pcld pcz pcsrc[2] we dst wsel
  wire [15:0] obs = {mem_rd, mem_wr, addr_sel_data, ir_load, alu_a_sel, alu_b_sel, alu_op,
                     pc_load, pc_load_if_zero, pc_src, rf_we, rf_dst_sel, rf_wdata_sel};

  function automatic logic [15:0] vec(input logic rd, wr, ad, ir, a, input logic [1:0] b, op,
                                      input logic pl, pz, input logic [1:0] ps,
                                      input logic we, dst, ws);
    return {rd, wr, ad, ir, a, b, op, pl, pz, ps, we, dst, ws};
  endfunction

  localparam logic [15:0] V_FETCH = {1'b1,1'b0,1'b0,1'b1,1'b0,2'b01,2'b00,1'b1,1'b0,2'b00,1'b0,1'b0,1'b0};

  task automatic chk(input logic [15:0] exp, input string req);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b opcode=%b", req, obs, exp, opcode);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic run_instr(input logic [5:0] op);
    chk(V_FETCH, "R2");
    opcode = ~op;                 // R12-style: opcode in fetch has no effect (R2)
    tick;
    opcode = op;
    chk(vec(0,0,0,0,0,2'b11,2'b00,0,0,2'b00,0,0,0), "R3");
    tick;
    case (op)
      6'b100011, 6'b101011: begin
        chk(vec(0,0,0,0,1,2'b10,2'b00,0,0,2'b00,0,0,0), "R4");
        tick;
        if (op == 6'b100011) begin
          chk(vec(1,0,1,0,0,2'b00,2'b00,0,0,2'b00,0,0,0), "R5");
          tick;
          chk(vec(0,0,0,0,0,2'b00,2'b00,0,0,2'b00,1,0,1), "R6");
          tick;
        end else begin
          chk(vec(0,1,1,0,0,2'b00,2'b00,0,0,2'b00,0,0,0), "R7");
          tick;
        end
      end
      6'b000000: begin
        chk(vec(0,0,0,0,1,2'b00,2'b10,0,0,2'b00,0,0,0), "R8");
        tick;
        chk(vec(0,0,0,0,0,2'b00,2'b00,0,0,2'b00,1,1,0), "R8");
        tick;
      end
      6'b000100: begin
        chk(vec(0,0,0,0,1,2'b00,2'b01,0,1,2'b01,0,0,0), "R9");
        tick;
      end
      6'b000010: begin
        chk(vec(0,0,0,0,0,2'b00,2'b00,1,0,2'b10,0,0,0), "R10");
        tick;
      end
      default: ; // R11: straight back to fetch
    endcase
    chk(V_FETCH, (op inside {6'b100011,6'b101011,6'b000000,6'b000100,6'b000010}) ? "R2" : "R11");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    tick; tick; tick;
    chk(V_FETCH, "R1");
    rst = 0;
    for (int i = 0; i < 64; i++) run_instr(6'(i));
    // back-to-back mix without reset, opposite order
    for (int i = 63; i >= 0; i--) run_instr(6'(i));
    // reset mid-instruction: R1
    opcode = 6'b100011;
    tick; tick;
    rst = 1;
    tick;
    chk(V_FETCH, "R1");
    rst = 0;
    run_instr(6'b101011);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule